// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block runs one 12-bit successive-approximation conversion at a time. A start request drives the sampler into hold. The block then walks a trial code from the most significant bit down to the least significant bit on the output that feeds an external DAC. For each bit it reads a single comparator line and decides whether to keep that bit. It drives an active-low busy flag for the whole conversion and loads the final code into a result register for the output interfaces.

There are two ways to request a conversion, and both inputs are synchronized inside the block. The first is a rising edge on the convert-start line. The second is a falling edge on chip select while convert-start stays low. A conversion lasts a fixed number of clock cycles: a hold-settling window, one cycle per bit, and a short tail. With the default parameters this is 20 cycles, which is 8 µs at a 2.5 MHz clock. The analog parts are outside the block: sampler, DAC, comparator and reference.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, `busy_n_o` is 1, `hold_o` is 0, `dac_code_o` is 0 and `result_o` is 0.
- R2: A rising edge on `conv_start_i` while idle makes `busy_n_o` go low after the third rising clock edge that follows the input change (two synchronizer stages, then one state register).
- R3: A falling edge on `cs_n_i` while `conv_start_i` is low starts a conversion with the same latency as R2. A falling edge on `cs_n_i` while `conv_start_i` is high starts nothing.
- R4: `busy_n_o` stays low for exactly SETTLE_CYC + RES_BITS + TAIL_CYC cycles (20 by default).
- R5: `hold_o` is high for the first SETTLE_CYC + 1 cycles of the conversion (7 by default), ending with the cycle in which the MSB is decided. It is never high while `busy_n_o` is high.
- R6: The first trial code is the MSB alone (0x800). In each bit cycle the trial bit is kept when `cmp_i` is 1 (input at or above the DAC level) and cleared when it is 0, and the next lower bit is set for the following cycle. The second trial code is therefore (vin & 0x800) | 0x400.
- R7: With a comparator that reports vin >= code, the final `result_o` equals vin for every 12-bit vin, including 0 and 0xFFF.
- R8: `result_o` changes only in the cycle in which `busy_n_o` returns high. During a conversion it holds the previous result.
- R9: Start requests on either input while a conversion is running are ignored. No second conversion follows, and the result is that of the running conversion.
- R10: `dac_code_o` is 0 whenever `busy_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low reset |
| conv_start_i | input | 1 | Convert-start request, asynchronous, acts on its rising edge |
| cs_n_i | input | 1 | Chip select, active low; its falling edge starts a conversion when convert-start is low |
| cmp_i | input | 1 | Comparator result, 1 when the analog input is at or above the DAC level |
| hold_o | output | 1 | Sampler hold command |
| dac_code_o | output | 12 | Trial code to the DAC |
| busy_n_o | output | 1 | Busy/interrupt, low while converting |
| result_o | output | 12 | Last completed conversion result |

## Verification
The assertions check on every cycle that the busy window has the fixed length, that hold only occurs inside busy, that the result register moves only at the end of a conversion, and that the DAC code is idle outside a conversion. Only the bench scenarios can show the behaviour that depends on the comparator and the start pins. These are the exact start latency of each start mode and the blocking of chip select while convert-start is high. They also cover the rejection of requests that arrive mid-conversion, the bit-by-bit trial sequence, and that the code found equals the modelled input at the range ends and at mid-scale neighbours.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_BITS   = 2'd2,
        PH_TAIL   = 2'd3
    } sar_phase_e;

endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start_i,
    input  logic cs_n_i,
    input  logic busy_i,
    output logic start_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] conv_sh;
        logic [SYNC_STAGES-1:0] cs_sh;
        logic                   conv_prev;
        logic                   cs_prev;
    } det_t;

    det_t det_d, det_q;
    logic conv_s, cs_s;

    assign conv_s = det_q.conv_sh[SYNC_STAGES-1];
    assign cs_s   = det_q.cs_sh[SYNC_STAGES-1];

    always_comb begin
        det_d           = det_q;
        det_d.conv_sh   = {det_q.conv_sh[SYNC_STAGES-2:0], conv_start_i};
        det_d.cs_sh     = {det_q.cs_sh[SYNC_STAGES-2:0], cs_n_i};
        det_d.conv_prev = conv_s;
        det_d.cs_prev   = cs_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q.conv_sh   <= '0;
            det_q.cs_sh     <= '1;
            det_q.conv_prev <= 1'b0;
            det_q.cs_prev   <= 1'b1;
        end else begin
            det_q <= det_d;
        end
    end

    logic conv_rise, cs_fall_armed;
    assign conv_rise     = conv_s & ~det_q.conv_prev;
    assign cs_fall_armed = ~cs_s & det_q.cs_prev & ~conv_s;
    assign start_o       = ~busy_i & (conv_rise | cs_fall_armed);

endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_pkg::*;
#(
    parameter int RES_BITS   = 12,
    parameter int SETTLE_CYC = 6,
    parameter int TAIL_CYC   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cmp_i,
    output logic                busy_o,
    output logic                hold_o,
    output logic [RES_BITS-1:0] trial_o,
    output logic [RES_BITS-1:0] result_o
);

    localparam int MAXW = (SETTLE_CYC > TAIL_CYC) ? SETTLE_CYC : TAIL_CYC;
    localparam int CW   = $clog2(MAXW + 1);
    localparam int BW   = $clog2(RES_BITS);
    localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

    typedef struct packed {
        sar_phase_e          phase;
        logic [CW-1:0]       cnt;
        logic [BW-1:0]       bit_idx;
        logic [RES_BITS-1:0] trial;
        logic [RES_BITS-1:0] result;
        logic                hold;
        logic                busy;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase   = PH_SETTLE;
                    st_d.cnt     = CW'(SETTLE_CYC - 1);
                    st_d.bit_idx = BW'(RES_BITS - 1);
                    st_d.trial   = MSB_ONLY;
                    st_d.hold    = 1'b1;
                    st_d.busy    = 1'b1;
                end
            end
            PH_SETTLE: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_BITS;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_BITS: begin
                if (!cmp_i) begin
                    st_d.trial[st_q.bit_idx] = 1'b0;
                end
                if (st_q.bit_idx == BW'(RES_BITS - 1)) begin
                    st_d.hold = 1'b0;
                end
                if (st_q.bit_idx != '0) begin
                    st_d.trial[st_q.bit_idx - 1'b1] = 1'b1;
                    st_d.bit_idx = st_q.bit_idx - 1'b1;
                end else begin
                    st_d.phase = PH_TAIL;
                    st_d.cnt   = CW'(TAIL_CYC - 1);
                end
            end
            PH_TAIL: begin
                if (st_q.cnt == '0) begin
                    st_d.phase  = PH_IDLE;
                    st_d.result = st_q.trial;
                    st_d.trial  = '0;
                    st_d.busy   = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase   <= PH_IDLE;
            st_q.cnt     <= '0;
            st_q.bit_idx <= '0;
            st_q.trial   <= '0;
            st_q.result  <= '0;
            st_q.hold    <= 1'b0;
            st_q.busy    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign hold_o   = st_q.hold;
    assign trial_o  = st_q.trial;
    assign result_o = st_q.result;

    AST_HOLD_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hold |-> st_q.busy); // R5

    AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.result) |-> $fell(st_q.busy)); // R8

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int RES_BITS    = 12,
    parameter int SETTLE_CYC  = 6,
    parameter int TAIL_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_start_i,
    input  logic                cs_n_i,
    input  logic                cmp_i,
    output logic                hold_o,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic                busy_n_o,
    output logic [RES_BITS-1:0] result_o
);

    localparam int CONV_CYCLES = SETTLE_CYC + RES_BITS + TAIL_CYC;
    localparam int LW          = $clog2(CONV_CYCLES + 2);

    logic start_w;
    logic busy_w;

    sar_start_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_start_i(conv_start_i),
        .cs_n_i      (cs_n_i),
        .busy_i      (busy_w),
        .start_o     (start_w)
    );

    sar_core #(
        .RES_BITS  (RES_BITS),
        .SETTLE_CYC(SETTLE_CYC),
        .TAIL_CYC  (TAIL_CYC)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .cmp_i   (cmp_i),
        .busy_o  (busy_w),
        .hold_o  (hold_o),
        .trial_o (dac_code_o),
        .result_o(result_o)
    );

    assign busy_n_o = ~busy_w;

    // Independent busy-window length monitor for the checks below
    logic [LW-1:0] busy_len_d, busy_len_q;

    always_comb begin
        busy_len_d = '0;
        if (!busy_n_o && busy_len_q != '1) begin
            busy_len_d = busy_len_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_len_q <= '0;
        else        busy_len_q <= busy_len_d;
    end

    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n_o) |-> busy_len_q == LW'(CONV_CYCLES)); // R4

    AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy_n_o |-> dac_code_o == '0); // R10

endmodule

// File: tb/sar_conv_seq_tb_top.sv
module sar_conv_seq_tb_top;

    localparam int CLK_PERIOD = 400;
    localparam int NCONV      = 20;
    localparam int NHOLD      = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0;
    logic        cs_n = 1'b1;
    logic [11:0] vin = 12'h000;
    logic        cmp;
    logic        hold;
    logic [11:0] dac_code;
    logic        busy_n;
    logic [11:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Comparator model: 1 when the input is at or above the DAC level
    assign cmp = (vin >= dac_code);

    sar_conv_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_start_i(conv_start),
        .cs_n_i      (cs_n),
        .cmp_i       (cmp),
        .hold_o      (hold),
        .dac_code_o  (dac_code),
        .busy_n_o    (busy_n),
        .result_o    (result)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drives a start on one of the two inputs, then follows the conversion
    task automatic run_conv(input logic [11:0] v, input bit use_cs,
                            input logic [11:0] prev_res);
        int lat = 0;
        int len = 0;
        int hcnt = 0;
        vin = v;
        @(negedge clk);
        if (use_cs) cs_n = 1'b0;
        else        conv_start = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            lat++;
            if (!busy_n) break;
        end
        chk(use_cs ? "R3 start latency" : "R2 start latency", lat, 3);
        chk("R6 first trial", dac_code, 12'h800);
        while (!busy_n && len < 40) begin
            if (hold) hcnt++;
            if (len == NHOLD) chk("R6 second trial", dac_code, (v & 12'h800) | 12'h400);
            if (len == 10) chk("R8 result held", result, prev_res);
            @(negedge clk);
            len++;
        end
        chk("R4 busy length", len, NCONV);
        chk("R5 hold length", hcnt, NHOLD);
        chk("R7 result", result, v);
        chk("R10 dac idle", dac_code, 0);
        conv_start = 1'b0;
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 busy_n reset", busy_n, 1);
        chk("R1 hold reset", hold, 0);
        chk("R1 dac reset", dac_code, 0);
        chk("R1 result reset", result, 0);
    endtask

    task automatic t_cs_blocked;
        int starts = 0;
        @(negedge clk);
        conv_start = 1'b1;
        vin = 12'h123;
        repeat (30) @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!busy_n) starts++;
        end
        chk("R3 cs blocked while conv high", starts, 0);
        cs_n = 1'b1;
        conv_start = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_busy_ignore;
        int extra = 0;
        vin = 12'h5A3;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        conv_start = 1'b1;
        for (int i = 0; i < 40 && !busy_n; i++) @(negedge clk);
        chk("R9 result of first conversion", result, 12'h5A3);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!busy_n) extra++;
        end
        chk("R9 no restart", extra, 0);
        conv_start = 1'b0;
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_conv(12'hA5A, 1'b0, 12'h000);
        run_conv(12'h000, 1'b0, 12'hA5A);
        run_conv(12'hFFF, 1'b1, 12'h000);
        run_conv(12'h800, 1'b0, 12'hFFF);
        run_conv(12'h7FF, 1'b1, 12'h800);
        run_conv(12'h001, 1'b0, 12'h7FF);
        t_cs_blocked();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule